// File: doc/BRIEF.md
# Console Keyboard and Display Register Unit

This block sits on a 16-bit processor data bus and gives software four word-addressed registers through which it talks to a character keyboard and a character display. Each device has a status register, which carries a ready flag and an interrupt-enable flag, and a data register, which carries an 8-bit character. Software can poll the ready flags. It can also set an enable flag so that the block raises an interrupt request whenever that device is ready.

The keyboard side latches an incoming character and then refuses new characters until software reads the data register. The display side accepts one character when it is ready and then ignores further writes until the display reports that it is done. Bus reads return their data one clock after the read strobe. A read that hits no register of this block returns zero and raises a no-hit flag, so that an outer multiplexer can take memory data instead.

Top module: `console_regs`

## Requirements
- R1: After reset the keyboard ready flag is 0, the display ready flag is 1, both enable flags are 0, both interrupt requests are 0, and `bus_rdata`, `bus_nohit` and `disp_stb` are 0.
- R2: The registers sit at exact word addresses: keyboard status 16'hFE00, keyboard data 16'hFE02, display status 16'hFE04, display data 16'hFE06. A read is sampled at a clock edge, and its result appears on `bus_rdata` and `bus_nohit` after that same edge. A read of any other address returns 16'h0000 with `bus_nohit` = 1. A read of a mapped address gives `bus_nohit` = 0. In cycles with no read, both outputs are 0.
- R3: A `key_stb` pulse while the keyboard ready flag is 0 latches `key_char` and sets that flag. A read of keyboard data returns {8'h00, char}.
- R4: While the keyboard ready flag is 1, `key_stb` pulses are ignored and the latched character is kept.
- R5: A read of keyboard data clears the keyboard ready flag, so that the next `key_stb` is captured again. If a capture and a read happen in the same cycle, the capture wins.
- R6: A write to display data while the display ready flag is 1 clears that flag. After the same edge, `disp_stb` is 1 for exactly one cycle and `disp_char` equals the written bits [7:0].
- R7: A write to display data while the display ready flag is 0 is discarded: no `disp_stb` pulse, and the flag is unchanged.
- R8: A `disp_done` pulse sets the display ready flag at the edge that samples it. An accepted display write in the same cycle takes priority.
- R9: Status reads return {ready, enable, 14'b0}, with ready in bit 15 and enable in bit 14. A status write changes only the enable flag, from write-data bit 14. The ready flag is not writable.
- R10: `irq_kbd` and `irq_disp` are each 1 exactly when the ready flag and the enable flag of that device are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_nohit | output | 1 | Registered flag: read missed every register |
| key_char | input | 8 | Incoming keyboard character |
| key_stb | input | 1 | Keyboard character valid pulse |
| disp_char | output | 8 | Character sent to the display |
| disp_stb | output | 1 | One-cycle pulse with disp_char |
| disp_done | input | 1 | Display finished the last character |
| irq_kbd | output | 1 | Keyboard interrupt request |
| irq_disp | output | 1 | Display interrupt request |

## Verification
A ready flag that is stuck or set wrongly shows up on the next status read, one clock after that read. It also shows up at once on the interrupt line, whenever the matching enable flag is set. A character that is overwritten while the keyboard flag is held appears as a wrong value on the next data read. A display lockout that fails shows up as an extra `disp_stb` pulse right after the dropped write. The scoreboard pairs every read with a value worked out from the requirements, so an error in decoding or in the data mux is reported on the very read that exposes it.

// File: rtl/console_pkg.sv
package console_pkg;
  localparam int DATA_W = 16;
  localparam int CHAR_W = 8;
  localparam int NREG   = 4;
  localparam int RDY_BIT = DATA_W - 1;
  localparam int IEN_BIT = DATA_W - 2;

  typedef enum logic [1:0] {
    SEL_KSTAT = 2'd0,
    SEL_KDATA = 2'd1,
    SEL_DSTAT = 2'd2,
    SEL_DDATA = 2'd3
  } reg_sel_e;

  function automatic logic [DATA_W-1:0] stat_word(input logic rdy, input logic ien);
    logic [DATA_W-1:0] w;
    w = '0;
    w[RDY_BIT] = rdy;
    w[IEN_BIT] = ien;
    return w;
  endfunction
endpackage

// File: rtl/console_decode.sv
module console_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hFE00,
  parameter int NREG = 4,
  parameter int STRIDE = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   sel
);
  for (genvar i = 0; i < NREG; i++) begin : g_sel
    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(i * STRIDE);
    assign sel[i] = (addr == BASE + OFFS);
  end
endmodule

// File: rtl/console_kbd.sv
module console_kbd #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_stb,
  input  logic [CHAR_W-1:0] key_char,
  input  logic              data_rd,
  input  logic              stat_wr,
  input  logic              ien_in,
  output logic              ready,
  output logic              ien,
  output logic [CHAR_W-1:0] char_q
);
  logic capture;
  assign capture = key_stb & ~ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready  <= 1'b0;
      ien    <= 1'b0;
      char_q <= '0;
    end else begin
      if (capture) begin
        ready  <= 1'b1;
        char_q <= key_char;
      end else if (data_rd) begin
        ready <= 1'b0;
      end
      if (stat_wr) ien <= ien_in;
    end
  end

  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    key_stb && !ready |=> ready && char_q == $past(key_char));
  p_lock_r4: assert property (@(posedge clk) disable iff (rst)
    ready |=> $stable(char_q));
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    data_rd && !key_stb |=> !ready);
endmodule

// File: rtl/console_disp.sv
module console_disp #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic [CHAR_W-1:0] wchar,
  input  logic              done,
  input  logic              stat_wr,
  input  logic              ien_in,
  output logic              ready,
  output logic              ien,
  output logic [CHAR_W-1:0] out_char,
  output logic              out_stb
);
  logic accept;
  assign accept = data_wr & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready    <= 1'b1;
      ien      <= 1'b0;
      out_char <= '0;
      out_stb  <= 1'b0;
    end else begin
      out_stb <= accept;
      if (accept) begin
        out_char <= wchar;
        ready    <= 1'b0;
      end else if (done) begin
        ready <= 1'b1;
      end
      if (stat_wr) ien <= ien_in;
    end
  end

  p_send_r6: assert property (@(posedge clk) disable iff (rst)
    data_wr && ready |=> out_stb && !ready && out_char == $past(wchar));
  p_drop_r7: assert property (@(posedge clk) disable iff (rst)
    data_wr && !ready |=> !out_stb);
  p_done_r8: assert property (@(posedge clk) disable iff (rst)
    done && !(data_wr && ready) |=> ready);
  p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    out_stb |=> !out_stb);
endmodule

// File: rtl/console_regs.sv
module console_regs
  import console_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_nohit,
  input  logic [CHAR_W-1:0] key_char,
  input  logic              key_stb,
  output logic [CHAR_W-1:0] disp_char,
  output logic              disp_stb,
  input  logic              disp_done,
  output logic              irq_kbd,
  output logic              irq_disp
);
  logic [NREG-1:0]   sel;
  logic              hit;
  logic              k_rdy, k_ien, d_rdy, d_ien;
  logic [CHAR_W-1:0] k_char;
  logic [DATA_W-1:0] mux;

  console_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NREG(NREG), .STRIDE(2)) i_dec (
    .addr(bus_addr), .sel(sel)
  );
  assign hit = |sel;

  console_kbd #(.CHAR_W(CHAR_W)) i_kbd (
    .clk(clk), .rst(rst),
    .key_stb(key_stb), .key_char(key_char),
    .data_rd(bus_rd & sel[SEL_KDATA]),
    .stat_wr(bus_wr & sel[SEL_KSTAT]),
    .ien_in(bus_wdata[IEN_BIT]),
    .ready(k_rdy), .ien(k_ien), .char_q(k_char)
  );

  console_disp #(.CHAR_W(CHAR_W)) i_disp (
    .clk(clk), .rst(rst),
    .data_wr(bus_wr & sel[SEL_DDATA]),
    .wchar(bus_wdata[CHAR_W-1:0]),
    .done(disp_done),
    .stat_wr(bus_wr & sel[SEL_DSTAT]),
    .ien_in(bus_wdata[IEN_BIT]),
    .ready(d_rdy), .ien(d_ien),
    .out_char(disp_char), .out_stb(disp_stb)
  );

  always_comb begin
    mux = '0;
    if (sel[SEL_KSTAT]) mux = stat_word(k_rdy, k_ien);
    if (sel[SEL_KDATA]) mux = {{(DATA_W-CHAR_W){1'b0}}, k_char};
    if (sel[SEL_DSTAT]) mux = stat_word(d_rdy, d_ien);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_nohit <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? mux : '0;
      bus_nohit <= bus_rd & ~hit;
    end
  end

  assign irq_kbd  = k_rdy & k_ien;
  assign irq_disp = d_rdy & d_ien;

  p_nohit_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !hit |=> bus_nohit && bus_rdata == '0);
  p_hit_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_nohit && bus_rdata == '0);
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  p_stat_r9: assert property (@(posedge clk) disable iff (rst)
    bus_rd && sel[SEL_KSTAT] |=> bus_rdata[IEN_BIT-1:0] == '0);
endmodule

// File: tb/test_console_regs.sv
module test_console_regs;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] d;
    logic        nh;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_nohit;
  logic [7:0]  key_char = '0;
  logic        key_stb = 1'b0;
  logic [7:0]  disp_char;
  logic        disp_stb;
  logic        disp_done = 1'b0;
  logic        irq_kbd, irq_disp;

  int checks = 0;
  int errors = 0;
  bit ended = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  console_regs i_console_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_nohit(bus_nohit),
    .key_char(key_char), .key_stb(key_stb), .disp_char(disp_char), .disp_stb(disp_stb),
    .disp_done(disp_done), .irq_kbd(irq_kbd), .irq_disp(irq_disp)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: push the expectation, then drive one read cycle
  task automatic bus_read(input logic [15:0] a, input logic [15:0] d, input logic nh, input string tag);
    exp_t e;
    e.d = d; e.nh = nh; e.tag = tag;
    q.push_back(e);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic key(input logic [7:0] c);
    key_char = c; key_stb = 1'b1;
    @(negedge clk);
    key_stb = 1'b0;
  endtask

  // monitor: every sampled read is compared one edge later
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd && !rst) begin
        @(negedge clk);
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected read result actual %h expected none", bus_rdata);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " data"}, bus_rdata, e.d);
          check({e.tag, " nohit"}, {15'b0, bus_nohit}, {15'b0, e.nh});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_kbd", {15'b0, irq_kbd}, 16'h0);
    check("R1 irq_disp", {15'b0, irq_disp}, 16'h0);
    check("R1 disp_stb", {15'b0, disp_stb}, 16'h0);
    check("R1 rdata", bus_rdata, 16'h0);
    check("R1 nohit", {15'b0, bus_nohit}, 16'h0);
    bus_read(16'hFE00, 16'h0000, 1'b0, "R1 kbd status");
    bus_read(16'hFE04, 16'h8000, 1'b0, "R1 disp status");
    // R2 unmapped addresses
    bus_read(16'hFE08, 16'h0000, 1'b1, "R2 unmapped FE08");
    bus_read(16'hFE01, 16'h0000, 1'b1, "R2 unmapped FE01");
    bus_read(16'h0000, 16'h0000, 1'b1, "R2 unmapped 0000");
    @(negedge clk);
    check("R2 idle nohit", {15'b0, bus_nohit}, 16'h0);
    // R3 capture
    key(8'h41);
    bus_read(16'hFE00, 16'h8000, 1'b0, "R3 kbd ready");
    // R4 lockout
    key(8'h5A);
    bus_read(16'hFE02, 16'h0041, 1'b0, "R4 char kept");
    // R5 cleared by the data read
    bus_read(16'hFE00, 16'h0000, 1'b0, "R5 kbd cleared");
    key(8'h5A);
    bus_read(16'hFE02, 16'h005A, 1'b0, "R5 recapture");
    // R9 status write only touches enable
    bus_write(16'hFE00, 16'hFFFF);
    bus_read(16'hFE00, 16'h4000, 1'b0, "R9 ready not writable");
    check("R10 irq_kbd off", {15'b0, irq_kbd}, 16'h0);
    key(8'h33);
    check("R10 irq_kbd on", {15'b0, irq_kbd}, 16'h1);
    bus_read(16'hFE00, 16'hC000, 1'b0, "R9 kbd status both");
    bus_write(16'hFE00, 16'h0000);
    check("R10 irq_kbd disabled", {15'b0, irq_kbd}, 16'h0);
    bus_read(16'hFE00, 16'h8000, 1'b0, "R9 ready kept");
    bus_read(16'hFE02, 16'h0033, 1'b0, "R3 second char");
    // R6 display send
    bus_write(16'hFE06, 16'h1234);
    check("R6 disp_stb", {15'b0, disp_stb}, 16'h1);
    check("R6 disp_char", {8'h0, disp_char}, 16'h0034);
    @(negedge clk);
    check("R6 one pulse", {15'b0, disp_stb}, 16'h0);
    bus_read(16'hFE04, 16'h0000, 1'b0, "R6 disp busy");
    // R7 drop
    bus_write(16'hFE06, 16'h0055);
    check("R7 no strobe", {15'b0, disp_stb}, 16'h0);
    check("R7 char kept", {8'h0, disp_char}, 16'h0034);
    bus_read(16'hFE04, 16'h0000, 1'b0, "R7 still busy");
    // R8 done
    disp_done = 1'b1;
    @(negedge clk);
    disp_done = 1'b0;
    bus_read(16'hFE04, 16'h8000, 1'b0, "R8 ready again");
    // R10 display interrupt
    bus_write(16'hFE04, 16'h4000);
    check("R10 irq_disp on", {15'b0, irq_disp}, 16'h1);
    bus_read(16'hFE04, 16'hC000, 1'b0, "R9 disp status both");
    bus_write(16'hFE06, 16'h0077);
    check("R10 irq_disp off", {15'b0, irq_disp}, 16'h0);
    check("R6 second char", {8'h0, disp_char}, 16'h0077);
    bus_read(16'hFE06, 16'h0000, 1'b0, "R2 disp data reads zero");
    repeat (3) @(negedge clk);
    check("R2 queue drained", 16'(q.size()), 16'h0);
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule